// File: doc/BRIEF.md
# Conversion Rate and Ready Controller

This block decides when a converter's data register is written. It does not produce sample values. A result arrives on an input port, and the controller captures it only on the base tick that its own schedule selects. The schedule depends on three settings. The operating mode selects continuous conversion, a single conversion or power-down. A 3-bit rate select picks one of eight output periods. A 2-bit divider select stretches the chosen period by 1, 2, 4 or 8. Each output period is a count of base ticks taken from a table that is computed at elaboration from the tick frequency.

After a start or any reconfiguration, the first result waits for a settling time of two output periods. Later results in continuous mode follow one period apart. An active-low ready flag, `rdy_n`, tells a reader when it is safe to read. The flag goes high one tick before every data-register update, so a read cannot overlap the write. It goes low on the tick after the update to announce new data. It returns high once a read of the data register completes, so each result is announced only once.

When a single conversion has delivered its result, the controller writes power-down back into its mode register and stops.

Top module: `conv_rate_ctrl`

## Requirements
- R1: After reset, the controller is in continuous mode (`mode_q`=00) with divider 00 and rate 100. `rdy_n` is 1, `data_q` is 0 and `load_stb` is 0. The first load comes 144 ticks after the last reset edge.
- R2: In continuous mode, loads repeat every base<<div ticks. With the default tick rate of 1200, the base for rate select 0 to 7 is 10, 12, 36, 60, 72, 72, 90 and 126. Divider select 0 to 3 gives a shift of 0 to 3.
- R3: A write to the configuration, or a mode write of 00 or 10, restarts the schedule. The first load then comes 2*period ticks after the write edge. A write on the edge where a load was due cancels that load.
- R4: `rdy_n` is 1 on the tick before every load and stays 1 on the load edge.
- R5: On the tick after a load, `rdy_n` goes to 0. `load_stb` pulses for one cycle, and `data_q` holds the `result_in` value sampled on the load edge.
- R6: `rd_done` sets `rdy_n` to 1 on the next edge. If `rd_done` falls on the edge that would lower `rdy_n`, `rd_done` wins and that result is not announced again.
- R7: A mode write of 10 produces exactly one load, 2*period ticks later. On that same edge, `mode_q` becomes 11. No further loads follow, and `rdy_n` still goes to 0 on the next tick.
- R8: A mode write of 11 or 01 stores 11 and sets `rdy_n` to 1 on the next edge, and no loads occur while in that state. A configuration write made during power-down is kept and sets the period of the next start.
- R9: The schedule advances only on cycles where `tick` is 1. Cycles without a tick delay every load by their number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base tick enable for the schedule |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value: 00 continuous, 01 reserved, 10 single, 11 power-down |
| cfg_wr | input | 1 | Rate and divider write strobe |
| cfg_div | input | 2 | Divider select, period shifted left by this |
| cfg_rate | input | 3 | Rate select, index into the period table |
| result_in | input | DATA_W | Result value offered for capture |
| rd_done | input | 1 | Pulse when a data-register read completes |
| mode_q | output | 2 | Current mode register |
| load_stb | output | 1 | One-cycle pulse after each data-register load |
| rdy_n | output | 1 | Ready flag, low means unread new data |
| data_q | output | DATA_W | Data register |

## Verification
Two pairs of events can land on the same edge. The first pair is the post-load release of `rdy_n` and a completed read. The bench raises `rd_done` right after it sees `load_stb`, and it expects `rdy_n` to stay high through the following ticks. The second pair is a due load and a configuration write. The bench counts ticks from one load and places the write on exactly the edge of the next load. It expects no `load_stb` on that edge and a fresh settling interval of two new periods after it.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [1:0] {
    MD_CONT = 2'b00,
    MD_RSVD = 2'b01,
    MD_ONCE = 2'b10,
    MD_OFF  = 2'b11
  } mode_e;

  // Output rate in tenths of a hertz at full clock, per rate select.
  function automatic int unsigned rate_tenths(input int unsigned idx);
    case (idx)
      0: return 1200;
      1: return 1000;
      2: return 333;
      3: return 200;
      4: return 166;
      5: return 167;
      6: return 133;
      default: return 95;
    endcase
  endfunction

  // Rounded count of base ticks per output period.
  function automatic int unsigned base_ticks(input int unsigned hz, input int unsigned idx);
    int unsigned r;
    r = rate_tenths(idx);
    return (hz * 10 + r / 2) / r;
  endfunction

  function automatic int unsigned max_base(input int unsigned hz, input int unsigned n);
    int unsigned m;
    m = 0;
    for (int unsigned i = 0; i < n; i++)
      if (base_ticks(hz, i) > m) m = base_ticks(hz, i);
    return m;
  endfunction

endpackage

// File: rtl/crc_period_calc.sv
module crc_period_calc #(
  parameter int unsigned TICK_HZ = 1200,
  parameter int unsigned DIV_W   = 2,
  parameter int unsigned RATE_W  = 3,
  parameter int unsigned CNT_W   = 12
) (
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [RATE_W-1:0] rate_sel,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  settle
);
  import crc_pkg::*;

  localparam int unsigned RATE_N = 1 << RATE_W;

  logic [CNT_W-1:0] lut [RATE_N];

  for (genvar i = 0; i < RATE_N; i++) begin : g_lut
    assign lut[i] = CNT_W'(base_ticks(TICK_HZ, i));
  end

  assign period = lut[rate_sel] << div_sel;
  assign settle = period << 1;

endmodule

// File: rtl/crc_interval_timer.sv
module crc_interval_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] settle,
  input  logic [CNT_W-1:0] period,
  output logic             due,
  output logic             warn
);

  logic [CNT_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      rem <= settle;
    end else if (run && tick) begin
      if (rem == CNT_W'(1)) rem <= period;
      else                  rem <= rem - CNT_W'(1);
    end
  end

  assign due  = run && tick && (rem == CNT_W'(1));
  assign warn = run && tick && (rem == CNT_W'(2));

endmodule

// File: rtl/crc_ready_flag.sv
module crc_ready_flag (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic force_hi,
  input  logic warn,
  input  logic due,
  input  logic rd_done,
  output logic rdy_n
);

  logic pend;

  always_ff @(posedge clk) begin
    if (rst || force_hi) begin
      rdy_n <= 1'b1;
      pend  <= 1'b0;
    end else if (rd_done) begin
      rdy_n <= 1'b1;
      pend  <= due;
    end else begin
      if (warn) rdy_n <= 1'b1;
      if (due) begin
        pend <= 1'b1;
      end else if (pend && tick) begin
        rdy_n <= 1'b0;
        pend  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/conv_rate_ctrl.sv
module conv_rate_ctrl #(
  parameter int unsigned TICK_HZ  = 1200,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DIV_W    = 2,
  parameter int unsigned RATE_W   = 3,
  parameter int unsigned RATE_RST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  input  logic              cfg_wr,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [DATA_W-1:0] result_in,
  input  logic              rd_done,
  output logic [1:0]        mode_q,
  output logic              load_stb,
  output logic              rdy_n,
  output logic [DATA_W-1:0] data_q
);
  import crc_pkg::*;

  localparam int unsigned MAX_SHIFT  = (1 << DIV_W) - 1;
  localparam int unsigned MAX_SETTLE = max_base(TICK_HZ, 1 << RATE_W) * 2 * (1 << MAX_SHIFT);
  localparam int unsigned CNT_W      = $clog2(MAX_SETTLE + 1);

  logic [DIV_W-1:0]  div_q, div_nx;
  logic [RATE_W-1:0] rate_q, rate_nx;
  logic [1:0]        mode_norm, mode_nx;
  logic              active_q, active_nx, any_wr;
  logic              restart, force_hi, run, due, warn;
  logic [CNT_W-1:0]  period, settle;

  assign mode_norm = (mode_wdata == MD_RSVD) ? MD_OFF : mode_wdata;
  assign mode_nx   = rst ? MD_CONT : (mode_wr ? mode_norm : mode_q);
  assign div_nx    = rst ? '0 : (cfg_wr ? cfg_div : div_q);
  assign rate_nx   = rst ? RATE_W'(RATE_RST) : (cfg_wr ? cfg_rate : rate_q);

  assign active_q  = (mode_q == MD_CONT) || (mode_q == MD_ONCE);
  assign active_nx = (mode_nx == MD_CONT) || (mode_nx == MD_ONCE);
  assign any_wr    = mode_wr || cfg_wr;
  assign restart   = any_wr && active_nx;
  assign force_hi  = any_wr && (active_nx || mode_wr);
  assign run       = active_q && !any_wr;

  crc_period_calc #(
    .TICK_HZ(TICK_HZ), .DIV_W(DIV_W), .RATE_W(RATE_W), .CNT_W(CNT_W)
  ) u_period (
    .div_sel(div_nx), .rate_sel(rate_nx), .period(period), .settle(settle)
  );

  crc_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .restart(restart),
    .settle(settle), .period(period), .due(due), .warn(warn)
  );

  crc_ready_flag u_ready (
    .clk(clk), .rst(rst), .tick(tick), .force_hi(force_hi),
    .warn(warn), .due(due), .rd_done(rd_done), .rdy_n(rdy_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MD_CONT;
      div_q    <= '0;
      rate_q   <= RATE_W'(RATE_RST);
      data_q   <= '0;
      load_stb <= 1'b0;
    end else begin
      div_q    <= div_nx;
      rate_q   <= rate_nx;
      load_stb <= due;
      if (due) begin
        data_q <= result_in;
        mode_q <= (mode_q == MD_ONCE) ? MD_OFF : mode_q;
      end else begin
        mode_q <= mode_nx;
      end
    end
  end

endmodule

// File: rtl/conv_rate_ctrl_chk.sv
module conv_rate_ctrl_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_done,
  input logic [DATA_W-1:0] result_in,
  input logic [1:0]        mode_q,
  input logic              load_stb,
  input logic              rdy_n,
  input logic [DATA_W-1:0] data_q
);

  // R4
  rdy_before_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> (rdy_n && $past(rdy_n)));

  // R5
  load_data_chk: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> (data_q == $past(result_in)));

  // R5
  load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb);

  // R6
  read_sets_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_done) |-> rdy_n);

  // R7
  single_to_off_chk: assert property (@(posedge clk) disable iff (rst)
    (load_stb && $past(mode_q) == 2'b10) |-> (mode_q == 2'b11));

  // R8
  off_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b11 && $past(mode_q) == 2'b11) |-> !load_stb);

  // R8
  no_rsvd_mode_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'b01);

endmodule

bind conv_rate_ctrl conv_rate_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_done(rd_done), .result_in(result_in),
  .mode_q(mode_q), .load_stb(load_stb), .rdy_n(rdy_n), .data_q(data_q)
);

// File: tb/conv_rate_ctrl_tb_top.sv
module conv_rate_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_wdata = 2'b00;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_div = 2'b00;
  logic [2:0]  cfg_rate = 3'b000;
  logic [15:0] result_in = 16'h0000;
  logic        rd_done = 1'b0;
  logic [1:0]  mode_q;
  logic        load_stb;
  logic        rdy_n;
  logic [15:0] data_q;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int loads = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  conv_rate_ctrl dut_i (
    .clk(clk), .rst(rst), .tick(tick), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_rate(cfg_rate), .result_in(result_in),
    .rd_done(rd_done), .mode_q(mode_q), .load_stb(load_stb), .rdy_n(rdy_n), .data_q(data_q)
  );

  // Stimulus vectors: {div, rate}
  localparam logic [4:0] VEC [6] = '{5'b00_000, 5'b01_001, 5'b10_011, 5'b11_111, 5'b00_100, 5'b11_010};

  function automatic int base_of(input int r);
    case (r)
      0: return 10;  1: return 12;  2: return 36;  3: return 60;
      4: return 72;  5: return 72;  6: return 90;  default: return 126;
    endcase
  endfunction

  function automatic int per_of(input int d, input int r);
    return base_of(r) << d;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (load_stb) loads++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (load_stb) break;
    end
  endtask

  task automatic wr_cfg(input int d, input int r);
    cfg_wr = 1'b1; cfg_div = 2'(d); cfg_rate = 3'(r);
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr_mode(input logic [1:0] m);
    mode_wr = 1'b1; mode_wdata = m;
    @(posedge clk); @(negedge clk);
    mode_wr = 1'b0;
  endtask

  initial begin
    int n, p, d, r, l0;
    repeat (4) @(negedge clk);
    chk("R1", "mode after reset", mode_q, 0);
    chk("R1", "rdy_n after reset", rdy_n, 1);
    chk("R1", "load after reset", load_stb, 0);
    chk("R1", "data after reset", data_q, 0);
    rst = 1'b0;
    result_in = 16'h1357;
    measure(n);
    chk("R1", "first load ticks", n, 144);
    chk("R5", "data at first load", data_q, 16'h1357);

    // Table walk: settling then steady period per configuration
    for (int k = 0; k < 6; k++) begin
      d = int'(VEC[k][4:3]); r = int'(VEC[k][2:0]); p = per_of(d, r);
      result_in = 16'(16'h2000 + k);
      wr_cfg(d, r);
      measure(n);
      chk("R3", "settle ticks", n, 2 * p);
      chk("R5", "data after settle", data_q, 16'h2000 + k);
      chk("R4", "rdy_n at load", rdy_n, 1);
      result_in = 16'(16'h3000 + k);
      step(1);
      chk("R5", "rdy_n after load", rdy_n, 0);
      measure(n);
      chk("R2", "period ticks", n, p - 1);
      chk("R5", "data next result", data_q, 16'h3000 + k);
    end

    // Pre-load ready and write on the due edge
    wr_cfg(0, 0);
    measure(n);
    step(1);
    chk("R5", "rdy_n low after load", rdy_n, 0);
    step(10 - 3);
    chk("R4", "rdy_n two ticks before load", rdy_n, 0);
    step(1);
    chk("R4", "rdy_n one tick before load", rdy_n, 1);
    l0 = loads;
    wr_cfg(0, 1);
    chk("R3", "load cancelled by write", loads - l0, 0);
    measure(n);
    chk("R3", "settle after coincident write", n, 2 * per_of(0, 1));

    // Read on the release edge
    rd_done = 1'b1;
    step(1);
    rd_done = 1'b0;
    chk("R6", "rdy_n read wins release", rdy_n, 1);
    step(5);
    chk("R6", "rdy_n stays high after read", rdy_n, 1);

    // Single conversion
    wr_cfg(0, 0);
    wr_mode(2'b10);
    measure(n);
    chk("R7", "single settle ticks", n, 20);
    chk("R7", "mode after single", mode_q, 3);
    step(1);
    chk("R7", "rdy_n after single", rdy_n, 0);
    l0 = loads;
    step(60);
    chk("R7", "no loads after single", loads - l0, 0);
    rd_done = 1'b1;
    step(1);
    rd_done = 1'b0;
    chk("R6", "rdy_n after read", rdy_n, 1);

    // Power-down and reserved mode
    wr_mode(2'b00);
    measure(n);
    step(1);
    wr_mode(2'b11);
    chk("R8", "rdy_n forced high", rdy_n, 1);
    chk("R8", "mode off", mode_q, 3);
    wr_mode(2'b01);
    chk("R8", "reserved stored as off", mode_q, 3);
    wr_cfg(1, 0);
    l0 = loads;
    step(100);
    chk("R8", "no loads in power-down", loads - l0, 0);
    wr_mode(2'b00);
    measure(n);
    chk("R8", "restart uses stored cfg", n, 2 * per_of(1, 0));

    // Tick gating
    wr_cfg(0, 0);
    tick = 1'b0;
    l0 = loads;
    step(50);
    chk("R9", "no loads without ticks", loads - l0, 0);
    tick = 1'b1;
    measure(n);
    chk("R9", "settle after gap", n, 20);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule